// File: doc/BRIEF.md
# Edge-Triggered Pin Event Unit

This block watches one bank of 32 general-purpose inputs and turns selected transitions into interrupt events. The inputs are assumed to be synchronised to the block clock already. Each pin has its own configuration word. The word selects which transitions count (rising, falling, either, or none) and can enable a debounce filter. The filter's hold time is a power of two in units of an external millisecond tick. A qualifying transition sets a sticky bit in an event status register. The single bank interrupt is high whenever any status bit is set on a pin that is not masked.

Software uses a simple register port: a write strobe with address and data, and a combinational read bus. Status bits are cleared by writing ones to the status offset. The mask is changed through two offsets: one that sets mask bits and one that clears them. The filtered pin levels can also be read back. A typical driver masks every pin and clears every status bit after reset. It then programs each pin's configuration and unmasks the pins it wants to serve. From the interrupt handler, it clears the bits it has seen.

Top module: `pin_event_bank`

## Requirements
- R1: After reset the status register reads 0, the mask reads all ones, every configuration word reads 0, and the interrupt output is low.
- R2: Configuration word bits [1:0] select the trigger. Value 1 (rising) sets the pin's status bit on a filtered 0-to-1 transition and ignores 1-to-0.
- R3: Trigger value 2 (falling) sets the status bit on a filtered 1-to-0 transition only.
- R4: Trigger value 3 sets the status bit on either transition.
- R5: Trigger value 0 records no event, whatever the pin does.
- R6: Status bits are sticky. A write to offset 0x00 clears exactly the bits written as one and leaves the others.
- R7: A write to offset 0x04 sets the mask bits written as one. A write to offset 0x08 clears them. Both offsets read back the current mask.
- R8: The interrupt is high exactly when some status bit is set whose mask bit is clear. Events on masked pins are still recorded in status.
- R9: If a transition is accepted in the same cycle that software clears that pin's status bit, the bit stays set.
- R10: With bit 2 of the configuration word set, a new pin level is accepted only after 2^r tick pulses with the input held at that level, where r is bits [5:3]. Any return to the old level restarts the count.
- R11: With debounce off, a transition seen by the block at one clock edge is recorded in status at that same edge.
- R12: The configuration word of pin i is written and read at offset 0x40 + 4*i. Offset 0x0C reads the filtered level of every pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per millisecond for the debounce counters |
| pinIn | input | 32 | Synchronised pin levels |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data for `addr` |
| irq | output | 1 | Bank interrupt |

## Verification
The bench collides a write-one-to-clear with a newly accepted transition on the same bit. A design that lets the clear win would silently lose that event. The debounce filter is exercised by stopping one tick short of the period and by a glitch back to the old level part-way through. A filter that counted total ticks, or did not restart its count, would accept the level early. Masked pins are driven to check that their status bit is still recorded while the interrupt stays low. A partial clear checks that only the bits written as one are cleared, and a disabled trigger type is toggled to check that it records no event.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
  localparam int DATA_W = 32;
  localparam int RATE_W = 3;

  // Register byte offsets
  localparam int OFS_STATUS  = 'h00;
  localparam int OFS_MASKSET = 'h04;
  localparam int OFS_MASKCLR = 'h08;
  localparam int OFS_LEVEL   = 'h0C;
  localparam int CFG_BASE    = 'h40;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_ANY  = 2'd3
  } trig_e;

  // bits [1:0] trigger, bit 2 debounce enable, bits [5:3] rate
  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              dbEn;
    trig_e             trig;
  } pin_cfg_t;

  localparam int CFG_W = $bits(pin_cfg_t);

  typedef struct packed {
    logic clrStatus;
    logic setMask;
    logic clrMask;
    logic wrCfg;
  } reg_strobe_t;
endpackage

// File: rtl/pin_filter.sv
module pin_filter
  import pin_event_pkg::*;
#(
  parameter int RW = RATE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          rawIn,
  input  logic          dbEn,
  input  logic [RW-1:0] rate,
  output logic          level,
  output logic          levelNext
);
  localparam int CNT_W = 1 << RW;

  logic [CNT_W-1:0] cntQ, cntNext, lastCnt;
  logic             levelQ;

  assign lastCnt = (CNT_W'(1) << rate) - CNT_W'(1);

  always_comb begin
    levelNext = levelQ;
    cntNext   = cntQ;
    if (!dbEn) begin
      levelNext = rawIn;
      cntNext   = '0;
    end else if (rawIn == levelQ) begin
      cntNext = '0;
    end else if (tick) begin
      if (cntQ == lastCnt) begin
        levelNext = rawIn;
        cntNext   = '0;
      end else begin
        cntNext = cntQ + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= 1'b0;
      cntQ   <= '0;
    end else begin
      levelQ <= levelNext;
      cntQ   <= cntNext;
    end
  end

  assign level = levelQ;
endmodule

// File: rtl/pin_event_datapath.sv
module pin_event_datapath
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic [NUM_PINS-1:0] pinIn,
  input  reg_strobe_t         strobe,
  input  logic [IDX_W-1:0]    cfgIdx,
  input  logic [DATA_W-1:0]   wrData,
  output logic [NUM_PINS-1:0] statusQ,
  output logic [NUM_PINS-1:0] maskQ,
  output logic [NUM_PINS-1:0] levels,
  output pin_cfg_t            selCfg,
  output logic                irq
);
  pin_cfg_t            cfgQ [NUM_PINS];
  logic [NUM_PINS-1:0] evt;
  logic [NUM_PINS-1:0] wrBits;

  assign wrBits = wrData[NUM_PINS-1:0];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic lvl, lvlNext, changed;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgQ[i] <= '0;
      end else if (strobe.wrCfg && cfgIdx == IDX_W'(i)) begin
        cfgQ[i] <= pin_cfg_t'(wrData[CFG_W-1:0]);
      end
    end

    pin_filter #(.RW(RATE_W)) u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .tick     (tick),
      .rawIn    (pinIn[i]),
      .dbEn     (cfgQ[i].dbEn),
      .rate     (cfgQ[i].rate),
      .level    (lvl),
      .levelNext(lvlNext)
    );

    assign changed   = lvl ^ lvlNext;
    assign levels[i] = lvl;

    always_comb begin
      unique case (cfgQ[i].trig)
        TRIG_RISE: evt[i] = changed & lvlNext;
        TRIG_FALL: evt[i] = changed & ~lvlNext;
        TRIG_ANY:  evt[i] = changed;
        default:   evt[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '1;
    end else begin
      statusQ <= (statusQ & ~(strobe.clrStatus ? wrBits : '0)) | evt;
      if (strobe.setMask) maskQ <= maskQ | wrBits;
      else if (strobe.clrMask) maskQ <= maskQ & ~wrBits;
    end
  end

  assign selCfg = cfgQ[cfgIdx];
  assign irq    = |(statusQ & ~maskQ);
endmodule

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] statusQ,
  input  logic [NUM_PINS-1:0] maskQ,
  input  logic [NUM_PINS-1:0] levels,
  input  pin_cfg_t            selCfg,
  output reg_strobe_t         strobe,
  output logic [IDX_W-1:0]    cfgIdx,
  output logic [DATA_W-1:0]   rdData
);
  logic [ADDR_W-1:0] cfgOff;
  logic              inCfg;

  assign cfgOff = addr - ADDR_W'(CFG_BASE);
  assign cfgIdx = cfgOff[IDX_W+1:2];
  assign inCfg  = (int'(addr) >= CFG_BASE) && (int'(cfgOff >> 2) < NUM_PINS)
                  && (addr[1:0] == 2'b00);

  always_comb begin
    strobe.clrStatus = wrEn && (addr == ADDR_W'(OFS_STATUS));
    strobe.setMask   = wrEn && (addr == ADDR_W'(OFS_MASKSET));
    strobe.clrMask   = wrEn && (addr == ADDR_W'(OFS_MASKCLR));
    strobe.wrCfg     = wrEn && inCfg;
  end

  always_comb begin
    rdData = '0;
    if (inCfg) begin
      rdData[CFG_W-1:0] = selCfg;
    end else begin
      case (int'(addr))
        OFS_STATUS:  rdData[NUM_PINS-1:0] = statusQ;
        OFS_MASKSET,
        OFS_MASKCLR: rdData[NUM_PINS-1:0] = maskQ;
        OFS_LEVEL:   rdData[NUM_PINS-1:0] = levels;
        default:     rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/pin_event_bank.sv
module pin_event_bank
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                irq
);
  localparam int IDX_W = $clog2(NUM_PINS);

  reg_strobe_t         strobe;
  logic [IDX_W-1:0]    cfgIdx;
  logic [NUM_PINS-1:0] statusQ, maskQ, levels;
  pin_cfg_t            selCfg;

  pin_event_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .statusQ(statusQ),
    .maskQ  (maskQ),
    .levels (levels),
    .selCfg (selCfg),
    .strobe (strobe),
    .cfgIdx (cfgIdx),
    .rdData (rdData)
  );

  pin_event_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .pinIn  (pinIn),
    .strobe (strobe),
    .cfgIdx (cfgIdx),
    .wrData (wrData),
    .statusQ(statusQ),
    .maskQ  (maskQ),
    .levels (levels),
    .selCfg (selCfg),
    .irq    (irq)
  );
endmodule

// File: rtl/pin_event_checks.sv
module pin_event_checks
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rstN,
  input reg_strobe_t         strobe,
  input logic [NUM_PINS-1:0] wrBits,
  input logic [NUM_PINS-1:0] status,
  input logic [NUM_PINS-1:0] mask,
  input logic                irq
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrStatus |=> ((status & $past(status)) == $past(status))); // R6

  AST_CLEAR_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrStatus |=> ((status & $past(status & ~wrBits)) == $past(status & ~wrBits))); // R6

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setMask |=> ((mask & $past(wrBits)) == $past(wrBits))); // R7

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrMask |=> ((mask & $past(wrBits)) == '0)); // R7

  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&mask) |-> !irq); // R8
endmodule

bind pin_event_bank pin_event_checks #(.NUM_PINS(NUM_PINS)) u_checks (
  .clk   (clk),
  .rstN  (rstN),
  .strobe(strobe),
  .wrBits(wrData[NUM_PINS-1:0]),
  .status(statusQ),
  .mask  (maskQ),
  .irq   (irq)
);

// File: tb/pin_event_bank_test.sv
module pin_event_bank_test;
  localparam logic [7:0] A_STAT = 8'h00, A_MSET = 8'h04, A_MCLR = 8'h08, A_LVL = 8'h0C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] pins = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;
  int          tests = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pin_event_bank uut (
    .clk(clk), .rstN(rstN), .tick(tick), .pinIn(pins), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  function automatic logic [7:0] cfgAddr(input int pin);
    return 8'(8'h40 + 4 * pin);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic pulseTick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic tidy();
    wr(A_MSET, 32'hFFFF_FFFF);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_STAT, d);      chk("R1 status", d, 32'h0);
    rd(A_MSET, d);      chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(cfgAddr(9), d);  chk("R1 cfg", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(cfgAddr(0), 32'h1);
    wr(A_MCLR, 32'h1);
    pins[0] = 1'b1; step();
    rd(A_STAT, d); chk("R2 R11 rise recorded", d & 32'h1, 32'h1);
    chk("R8 irq unmasked", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R6 cleared", d & 32'h1, 32'h0);
    chk("R8 irq drops", {31'b0, irq}, 32'h0);
    pins[0] = 1'b0; step(2);
    rd(A_STAT, d); chk("R2 fall ignored", d & 32'h1, 32'h0);
    tidy();
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wr(cfgAddr(1), 32'h2);
    pins[1] = 1'b1; step(2);
    rd(A_STAT, d); chk("R3 rise ignored", d & 32'h2, 32'h0);
    pins[1] = 1'b0; step();
    rd(A_STAT, d); chk("R3 fall recorded", d & 32'h2, 32'h2);
    tidy();
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(cfgAddr(2), 32'h3);
    pins[2] = 1'b1; step();
    rd(A_STAT, d); chk("R4 rise", d & 32'h4, 32'h4);
    wr(A_STAT, 32'h4);
    pins[2] = 1'b0; step();
    rd(A_STAT, d); chk("R4 fall", d & 32'h4, 32'h4);
    tidy();
  endtask

  task automatic t_off();
    logic [31:0] d;
    wr(cfgAddr(3), 32'h0);
    pins[3] = 1'b1; step(2);
    pins[3] = 1'b0; step(2);
    rd(A_STAT, d); chk("R5 disabled pin", d & 32'h8, 32'h0);
    rd(A_LVL, d);  chk("R12 level low", d & 32'h8, 32'h0);
  endtask

  task automatic t_masked();
    logic [31:0] d;
    wr(cfgAddr(4), 32'h1);
    wr(cfgAddr(0), 32'h1);
    pins[4] = 1'b1; pins[0] = 1'b1; step();
    rd(A_STAT, d); chk("R8 masked still recorded", d & 32'h11, 32'h11);
    chk("R8 masked irq low", {31'b0, irq}, 32'h0);
    rd(A_LVL, d);  chk("R12 level high", d & 32'h11, 32'h11);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R6 partial clear", d & 32'h11, 32'h10);
    wr(A_MCLR, 32'h10);
    rd(A_MCLR, d); chk("R7 mask clr readback", d, 32'hFFFF_FFEF);
    chk("R8 irq after unmask", {31'b0, irq}, 32'h1);
    wr(A_MSET, 32'h10);
    rd(A_MSET, d); chk("R7 mask set readback", d, 32'hFFFF_FFFF);
    chk("R8 irq after remask", {31'b0, irq}, 32'h0);
    pins[4] = 1'b0; pins[0] = 1'b0; step();
    tidy();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(cfgAddr(6), 32'h3);
    pins[6] = 1'b1; step();
    rd(A_STAT, d); chk("R9 first event", d & 32'h40, 32'h40);
    pins[6] = 1'b0;
    wr(A_STAT, 32'h40);
    rd(A_STAT, d); chk("R9 event beats clear", d & 32'h40, 32'h40);
    wr(A_STAT, 32'h40);
    rd(A_STAT, d); chk("R9 plain clear", d & 32'h40, 32'h0);
    tidy();
  endtask

  task automatic t_debounce();
    logic [31:0] d;
    wr(cfgAddr(5), 32'h15);
    rd(cfgAddr(5), d); chk("R12 cfg readback", d, 32'h15);
    wr(cfgAddr(31), 32'h3);
    rd(cfgAddr(31), d); chk("R12 last cfg readback", d, 32'h3);
    pins[5] = 1'b1; step(3);
    repeat (3) pulseTick();
    rd(A_LVL, d);  chk("R10 not yet after 3 ticks", d & 32'h20, 32'h0);
    rd(A_STAT, d); chk("R10 no early event", d & 32'h20, 32'h0);
    pulseTick();
    rd(A_LVL, d);  chk("R10 accepted on 4th tick", d & 32'h20, 32'h20);
    rd(A_STAT, d); chk("R10 event on accept", d & 32'h20, 32'h20);
    pins[5] = 1'b0;
    repeat (2) pulseTick();
    pins[5] = 1'b1; step();
    pins[5] = 1'b0;
    repeat (3) pulseTick();
    rd(A_LVL, d);  chk("R10 glitch restarts count", d & 32'h20, 32'h20);
    pulseTick();
    rd(A_LVL, d);  chk("R10 low accepted", d & 32'h20, 32'h0);
    wr(cfgAddr(7), 32'h5);
    pins[7] = 1'b1; step(5);
    rd(A_LVL, d);  chk("R10 rate0 waits tick", d & 32'h80, 32'h0);
    pulseTick();
    rd(A_LVL, d);  chk("R10 rate0 one tick", d & 32'h80, 32'h80);
    rd(A_STAT, d); chk("R10 rate0 event", d & 32'h80, 32'h80);
    tidy();
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step();
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_off();
    t_masked();
    t_collide();
    t_debounce();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule